// File: doc/BRIEF.md
# Privileged System Instruction Legality Checker

This block sits beside the decode stage of a RISC-V hart and handles four privileged system instructions: the machine-level trap return, the supervisor-level trap return, wait-for-interrupt, and the virtual-memory fence. Each cycle that the strobe is high, it classifies the 32-bit instruction word. It then decides from the current privilege level and three trap-control status bits whether the instruction may execute. One cycle later it presents a registered verdict.

A legal trap return raises a return request that says which return it is. A legal fence raises a flush request for the translation cache. The request carries a virtual address or an "all addresses" wildcard, and an address-space identifier or an "all identifiers" wildcard. A fence operand that names register zero becomes the wildcard. A legal wait-for-interrupt produces no request. Carrying out the return, the wait and the flush belongs to other blocks.

Top module: `sys_insn_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, kind, illegal, ret_req, ret_mach, flush_req and all flush payload outputs are zero.
- R2: Every output is registered. out_valid equals in_valid of the previous cycle, and the other outputs reflect the inputs that were sampled with that strobe.
- R3: Only words with opcode bits 6:0 = 1110011, funct3 bits 14:12 = 000 and rd bits 11:7 = 00000 are candidates. A candidate is classified as follows. Bits 31:20 = 0x302 with rs1 bits 19:15 = 0 is MRET (kind 1). Bits 31:20 = 0x102 with rs1 = 0 is SRET (kind 2). Bits 31:20 = 0x105 with rs1 = 0 is WFI (kind 3). Bits 31:25 = 0001001 is FENCE (kind 4). Any other word gives kind 0 with no illegal flag and no request.
- R4: MRET is legal only at privilege 11 (machine). A legal MRET sets ret_req with ret_mach = 1. At any other level, illegal is set instead.
- R5: SRET is illegal at privilege 00 (user). At privilege 01 (supervisor) it is illegal when trap_sret = 1. At privilege 11 it is always legal. A legal SRET sets ret_req with ret_mach = 0.
- R6: WFI is illegal at privilege 00, and illegal at privilege 01 when trap_wait = 1. When legal, it raises neither illegal nor any request.
- R7: FENCE is illegal at privilege 00, and illegal at any privilege when trap_vm = 1. Otherwise it sets flush_req.
- R8: For a flush with rs1 field = 0, flush_addr_all = 1 and flush_addr = 0. Otherwise flush_addr_all = 0 and flush_addr = rs1_val bits 38:0.
- R9: For a flush with rs2 field (bits 24:20) = 0, flush_asid_all = 1 and flush_asid = 0. Otherwise flush_asid_all = 0 and flush_asid = rs2_val bits 15:0.
- R10: Privilege value 10 is reserved. At that level all four instructions are illegal.
- R11: A cycle after in_valid was low shows out_valid = 0, kind 0, and all flags and payloads zero, whatever the other inputs were.
- R12: At most one of illegal, ret_req and flush_req is set in any cycle. The flush payload outputs are zero whenever flush_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| trap_sret | input | 1 | Trap supervisor return |
| trap_wait | input | 1 | Trap wait-for-interrupt at supervisor level |
| trap_vm | input | 1 | Trap virtual-memory fence |
| rs1_val | input | 64 | Value of the rs1 source register |
| rs2_val | input | 64 | Value of the rs2 source register |
| out_valid | output | 1 | Verdict valid |
| kind | output | 3 | 0 none, 1 MRET, 2 SRET, 3 WFI, 4 FENCE |
| illegal | output | 1 | Illegal-instruction exception |
| ret_req | output | 1 | Trap return request |
| ret_mach | output | 1 | Return is the machine-level one |
| flush_req | output | 1 | Translation-cache flush request |
| flush_addr_all | output | 1 | Flush every address |
| flush_addr | output | 39 | Virtual address to flush |
| flush_asid_all | output | 1 | Flush every address space |
| flush_asid | output | 16 | Address-space identifier to flush |

## Verification
On every cycle, the assertions check the one-cycle strobe delay and that the three outcomes exclude one another. They also check that the flush payload is zero without a request, that a return request only accompanies a return kind, and that user or reserved privilege always makes a recognised instruction illegal. Only the bench's sweeps can show the full legality table across every privilege and trap-bit combination, the exact wildcard and operand slicing of the flush, and the rejection of near-miss encodings.

// File: rtl/sysg_pkg.sv
package sysg_pkg;
  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_MRET  = 3'd1,
    KIND_SRET  = 3'd2,
    KIND_WFI   = 3'd3,
    KIND_FENCE = 3'd4
  } sys_kind_e;

  localparam logic [1:0] PRIV_USER = 2'b00;
  localparam logic [1:0] PRIV_SUP  = 2'b01;
  localparam logic [1:0] PRIV_MACH = 2'b11;

  localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
  localparam logic [11:0] TOP_MRET   = 12'h302;
  localparam logic [11:0] TOP_SRET   = 12'h102;
  localparam logic [11:0] TOP_WFI    = 12'h105;
  localparam logic [6:0]  TOP_FENCE  = 7'b0001001;
endpackage

// File: rtl/sysg_decode.sv
module sysg_decode
  import sysg_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output sys_kind_e         kind,
  output logic              rs1_zero,
  output logic              rs2_zero
);
  logic cand;
  logic src_zero;

  always_comb begin
    cand     = (insn[6:0] == OPC_SYSTEM) && (insn[14:12] == 3'b000) && (insn[11:7] == 5'd0);
    src_zero = (insn[19:15] == 5'd0);
    rs1_zero = src_zero;
    rs2_zero = (insn[24:20] == 5'd0);
    kind     = KIND_NONE;
    if (cand) begin
      if (insn[31:25] == TOP_FENCE)                 kind = KIND_FENCE;
      else if (src_zero && insn[31:20] == TOP_MRET) kind = KIND_MRET;
      else if (src_zero && insn[31:20] == TOP_SRET) kind = KIND_SRET;
      else if (src_zero && insn[31:20] == TOP_WFI)  kind = KIND_WFI;
    end
  end
endmodule

// File: rtl/sysg_legal.sv
module sysg_legal
  import sysg_pkg::*;
(
  input  sys_kind_e   kind,
  input  logic [1:0]  priv,
  input  logic        trap_sret,
  input  logic        trap_wait,
  input  logic        trap_vm,
  output logic        illegal,
  output logic        ret_req,
  output logic        ret_mach,
  output logic        flush_req
);
  logic is_m, is_s, ok;

  always_comb begin
    is_m = (priv == PRIV_MACH);
    is_s = (priv == PRIV_SUP);
    unique case (kind)
      KIND_MRET:  ok = is_m;
      KIND_SRET:  ok = is_m || (is_s && !trap_sret);
      KIND_WFI:   ok = is_m || (is_s && !trap_wait);
      KIND_FENCE: ok = (is_m || is_s) && !trap_vm;
      default:    ok = 1'b1;
    endcase
    illegal   = (kind != KIND_NONE) && !ok;
    ret_req   = ok && ((kind == KIND_MRET) || (kind == KIND_SRET));
    ret_mach  = ok && (kind == KIND_MRET);
    flush_req = ok && (kind == KIND_FENCE);
  end
endmodule

// File: rtl/sysg_fence_ops.sv
module sysg_fence_ops #(
  parameter int XLEN   = 64,
  parameter int VA_W   = 39,
  parameter int ASID_W = 16
) (
  input  logic              enable,
  input  logic              rs1_zero,
  input  logic              rs2_zero,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  output logic              addr_all,
  output logic [VA_W-1:0]   addr,
  output logic              asid_all,
  output logic [ASID_W-1:0] asid
);
  always_comb begin
    addr_all = enable && rs1_zero;
    asid_all = enable && rs2_zero;
    addr     = (enable && !rs1_zero) ? rs1_val[VA_W-1:0]   : '0;
    asid     = (enable && !rs2_zero) ? rs2_val[ASID_W-1:0] : '0;
  end
endmodule

// File: rtl/sys_insn_guard.sv
module sys_insn_guard
  import sysg_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int XLEN   = 64,
  parameter int VA_W   = 39,
  parameter int ASID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [1:0]        priv,
  input  logic              trap_sret,
  input  logic              trap_wait,
  input  logic              trap_vm,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  output logic              out_valid,
  output logic [2:0]        kind,
  output logic              illegal,
  output logic              ret_req,
  output logic              ret_mach,
  output logic              flush_req,
  output logic              flush_addr_all,
  output logic [VA_W-1:0]   flush_addr,
  output logic              flush_asid_all,
  output logic [ASID_W-1:0] flush_asid
);
  sys_kind_e         dec_kind;
  sys_kind_e         gated_kind;
  logic              rs1_zero, rs2_zero;
  logic              l_ill, l_ret, l_mach, l_flush;
  logic              f_addr_all, f_asid_all;
  logic [VA_W-1:0]   f_addr;
  logic [ASID_W-1:0] f_asid;

  logic              ctl_en, pay_en;
  logic [5:0]        ctl_d, ctl_q;
  logic [2:0]        kind_d, kind_q;
  logic              aall_q, sall_q;
  logic [VA_W-1:0]   addr_q;
  logic [ASID_W-1:0] asid_q;

  sysg_decode #(.INSN_W(INSN_W)) dec_i (
    .insn(insn), .kind(dec_kind), .rs1_zero(rs1_zero), .rs2_zero(rs2_zero)
  );

  assign gated_kind = in_valid ? dec_kind : KIND_NONE;

  sysg_legal legal_i (
    .kind(gated_kind), .priv(priv), .trap_sret(trap_sret), .trap_wait(trap_wait),
    .trap_vm(trap_vm), .illegal(l_ill), .ret_req(l_ret), .ret_mach(l_mach),
    .flush_req(l_flush)
  );

  sysg_fence_ops #(.XLEN(XLEN), .VA_W(VA_W), .ASID_W(ASID_W)) ops_i (
    .enable(l_flush), .rs1_zero(rs1_zero), .rs2_zero(rs2_zero),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .addr_all(f_addr_all), .addr(f_addr),
    .asid_all(f_asid_all), .asid(f_asid)
  );

  // next-state
  always_comb begin
    ctl_en = in_valid || ctl_q[0];
    pay_en = l_flush || ctl_q[4];
    ctl_d  = {1'b0, l_flush, l_mach, l_ret, l_ill, in_valid};
    kind_d = gated_kind;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      kind_q <= '0;
    end else if (ctl_en) begin
      ctl_q  <= ctl_d;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aall_q <= 1'b0;
      sall_q <= 1'b0;
      addr_q <= '0;
      asid_q <= '0;
    end else if (pay_en) begin
      aall_q <= f_addr_all;
      sall_q <= f_asid_all;
      addr_q <= f_addr;
      asid_q <= f_asid;
    end
  end

  assign out_valid      = ctl_q[0];
  assign illegal        = ctl_q[1];
  assign ret_req        = ctl_q[2];
  assign ret_mach       = ctl_q[3];
  assign flush_req      = ctl_q[4];
  assign kind           = kind_q;
  assign flush_addr_all = aall_q;
  assign flush_addr     = addr_q;
  assign flush_asid_all = sall_q;
  assign flush_asid     = asid_q;
endmodule

// File: rtl/sysg_chk.sv
module sysg_chk #(
  parameter int VA_W   = 39,
  parameter int ASID_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        priv,
  input logic              trap_vm,
  input logic              out_valid,
  input logic [2:0]        kind,
  input logic              illegal,
  input logic              ret_req,
  input logic              ret_mach,
  input logic              flush_req,
  input logic              flush_addr_all,
  input logic [VA_W-1:0]   flush_addr,
  input logic              flush_asid_all,
  input logic [ASID_W-1:0] flush_asid
);
  // R2
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) == out_valid);

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({illegal, ret_req, flush_req}) <= 1);

  // R12
  idle_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req |-> (flush_addr == '0 && flush_asid == '0 && !flush_addr_all && !flush_asid_all));

  // R4
  ret_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> ((kind == 3'd1 && ret_mach) || (kind == 3'd2 && !ret_mach)));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (kind == 3'd0 && !illegal && !ret_req && !flush_req));

  // R10
  low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind != 3'd0 && ($past(priv) == 2'b00 || $past(priv) == 2'b10)) |-> illegal);

  // R7
  vm_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind == 3'd4 && $past(trap_vm)) |-> (illegal && !flush_req));

  // R8
  wild_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_addr_all |-> (flush_req && flush_addr == '0));
endmodule

bind sys_insn_guard sysg_chk #(.VA_W(VA_W), .ASID_W(ASID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .priv(priv), .trap_vm(trap_vm),
  .out_valid(out_valid), .kind(kind), .illegal(illegal), .ret_req(ret_req),
  .ret_mach(ret_mach), .flush_req(flush_req), .flush_addr_all(flush_addr_all),
  .flush_addr(flush_addr), .flush_asid_all(flush_asid_all), .flush_asid(flush_asid)
);

// File: tb/sys_insn_guard_tb_top.sv
`timescale 1ns/1ps
module sys_insn_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn;
  logic [1:0]  priv;
  logic        trap_sret, trap_wait, trap_vm;
  logic [63:0] rs1_val, rs2_val;
  logic        out_valid, illegal, ret_req, ret_mach, flush_req, flush_addr_all, flush_asid_all;
  logic [2:0]  kind;
  logic [38:0] flush_addr;
  logic [15:0] flush_asid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sys_insn_guard dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .priv(priv),
    .trap_sret(trap_sret), .trap_wait(trap_wait), .trap_vm(trap_vm),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .out_valid(out_valid), .kind(kind),
    .illegal(illegal), .ret_req(ret_req), .ret_mach(ret_mach), .flush_req(flush_req),
    .flush_addr_all(flush_addr_all), .flush_addr(flush_addr),
    .flush_asid_all(flush_asid_all), .flush_asid(flush_asid)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fence_word(input logic [4:0] r2, input logic [4:0] r1);
    return {7'b0001001, r2, r1, 3'b000, 5'd0, 7'h73};
  endfunction

  function automatic logic [127:0] packed_out();
    return {out_valid, kind, illegal, ret_req, ret_mach, flush_req,
            flush_addr_all, flush_addr, flush_asid_all, flush_asid};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [1:0] p, input logic [2:0] tb,
                       input logic [63:0] a, input logic [63:0] b);
    logic [2:0]  ek;
    logic        ok, e_ill, e_ret, e_m, e_fl, e_aa, e_sa;
    logic [38:0] e_addr;
    logic [15:0] e_asid;
    string       req;
    @(negedge clk);
    in_valid = 1'b1; insn = w; priv = p;
    trap_sret = tb[0]; trap_wait = tb[1]; trap_vm = tb[2];
    rs1_val = a; rs2_val = b;
    // expected kind from the R3 field rules
    ek = 3'd0;
    if (w[6:0] == 7'h73 && w[14:7] == 8'd0) begin
      if (w[31:25] == 7'd9)                          ek = 3'd4;
      else if (w[19:15] == 0 && w[31:20] == 12'h302) ek = 3'd1;
      else if (w[19:15] == 0 && w[31:20] == 12'h102) ek = 3'd2;
      else if (w[19:15] == 0 && w[31:20] == 12'h105) ek = 3'd3;
    end
    case (ek)
      3'd1: begin ok = (p == 3); req = "R4"; end
      3'd2: begin ok = (p == 3) || (p == 1 && !tb[0]); req = "R5"; end
      3'd3: begin ok = (p == 3) || (p == 1 && !tb[1]); req = "R6"; end
      3'd4: begin ok = (p == 3 || p == 1) && !tb[2]; req = "R7"; end
      default: begin ok = 1'b1; req = "R3"; end
    endcase
    if (p == 2'b10 && ek != 0) req = "R10";
    e_ill  = (ek != 0) && !ok;
    e_ret  = ok && (ek == 1 || ek == 2);
    e_m    = ok && ek == 1;
    e_fl   = ok && ek == 4;
    e_aa   = e_fl && (w[19:15] == 0);
    e_sa   = e_fl && (w[24:20] == 0);
    e_addr = (e_fl && !e_aa) ? a[38:0] : '0;
    e_asid = (e_fl && !e_sa) ? b[15:0] : '0;
    @(posedge clk);
    #2;
    // R2: verdict appears one edge after the strobe
    check(req, packed_out(), {1'b1, ek, e_ill, e_ret, e_m, e_fl, e_aa, e_addr, e_sa, e_asid});
    // R12
    check("R12", 128'($countones({illegal, ret_req, flush_req}) <= 1), 128'd1);
    if (e_fl) begin
      check("R8", {flush_addr_all, flush_addr}, {e_aa, e_addr});
      check("R9", {flush_asid_all, flush_asid}, {e_sa, e_asid});
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] words [14];
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; priv = '0;
    trap_sret = 0; trap_wait = 0; trap_vm = 0; rs1_val = '0; rs2_val = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1
    check("R1", packed_out(), 128'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", packed_out(), 128'd0);

    words[0]  = 32'h3020_0073;
    words[1]  = 32'h1020_0073;
    words[2]  = 32'h1050_0073;
    words[3]  = fence_word(5'd0, 5'd0);
    words[4]  = fence_word(5'd7, 5'd0);
    words[5]  = fence_word(5'd0, 5'd12);
    words[6]  = fence_word(5'd31, 5'd1);
    words[7]  = 32'h3020_00F3;
    words[8]  = 32'h1050_8073;
    words[9]  = 32'h1200_1073;
    words[10] = 32'h0000_0073;
    words[11] = 32'h0000_0013;
    words[12] = 32'h1020_0077;
    words[13] = 32'h3040_0073;

    for (int i = 0; i < 14; i++)
      for (int p = 0; p < 4; p++)
        for (int t = 0; t < 8; t++)
          apply(words[i], p[1:0], t[2:0],
                64'hF0E1_D2C3_B4A5_9687 ^ (64'(i) << 33) ^ 64'(t * 977),
                64'h1357_9BDF_2468_ACE0 ^ 64'(p * 4099 + i));

    // R11: strobe low with a legal MRET on the inputs
    @(negedge clk);
    in_valid = 1'b0; insn = 32'h3020_0073; priv = 2'b11;
    @(posedge clk); #2;
    check("R11", packed_out(), 128'd0);
    @(posedge clk); #2;
    check("R11", packed_out(), 128'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule